// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit address pointers for a processor datapath and presents one of them, picked by a select bit, as the active memory address. Software loads either pointer one byte at a time. A step command moves the active pointer up or down by one. Each pointer has its own direction bit, so one pointer can count up while the other counts down.

Two optional behaviours make block copies faster. The first is an automatic step of the active pointer after an external data access. The second is an automatic flip of the select bit after each instruction that uses a pointer. With both enabled, a copy loop alternates between the source and destination pointers, and neither pointer needs an explicit step or select write. Instruction decoding and the memory access itself are outside this block. The block only receives strobes that say when these events happen.

Top module: `dptr_pair`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both pointers read zero, `ctl_q` reads zero and `addr` reads zero.
- R2: A `ctl_we` pulse stores `ctl_wdata` into `ctl_q` on the next clock edge. The control fields are: bit 0 select, bit 1 toggle enable, bit 2 direction of pointer 0, bit 3 direction of pointer 1, bit 4 auto-step enable.
- R3: `addr` always equals pointer 1 when the select bit is 1, and pointer 0 when the select bit is 0.
- R4: `ld_lo` writes `ld_data` into bits 7:0 of the pointer named by `ld_idx`, and `ld_hi` writes bits 15:8 of that pointer. Both strobes may be given in the same cycle. The other pointer keeps its value.
- R5: A `step_cmd` pulse adds one to the active pointer when that pointer's direction bit is 0, and subtracts one when the bit is 1. The inactive pointer does not change.
- R6: Stepping up from FFFFh gives 0000h. Stepping down from 0000h gives FFFFh.
- R7: `auto_step` steps the active pointer in the same way as `step_cmd`, but only when the auto-step enable bit is 1. When that bit is 0, `auto_step` has no effect.
- R8: When `step_cmd` and an enabled `auto_step` arrive in the same cycle, the pointer moves by exactly one.
- R9: When the toggle enable bit is 1, a `ptr_use` pulse inverts the select bit. When the toggle enable bit is 0, `ptr_use` has no effect. A `ctl_we` in the same cycle overrides the toggle.
- R10: When a byte load targets the active pointer in the same cycle as a step, the load is applied and the step is dropped for that pointer.
- R11: A step uses the select and direction values held before the clock edge, even when a control write or a toggle changes them at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_lo | input | 1 | Load the low byte of the addressed pointer |
| ld_hi | input | 1 | Load the high byte of the addressed pointer |
| ld_idx | input | 1 | Pointer addressed by the byte loads |
| ld_data | input | 8 | Byte value to load |
| step_cmd | input | 1 | Step the active pointer |
| auto_step | input | 1 | Data-access strobe for the optional auto-step |
| ptr_use | input | 1 | An instruction used the pointer (toggle trigger) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control register write value |
| addr | output | 16 | Active pointer value |
| ptr0_q | output | 16 | Pointer 0 readback |
| ptr1_q | output | 16 | Pointer 1 readback |
| ctl_q | output | 5 | Control register readback |

## Verification
The hardest situations to reach are cycles in which several events land on the same edge. Examples are a byte load hitting the pointer that is being stepped, a control write colliding with a toggle, and a step whose select or direction is rewritten at that same edge. In each case the result depends on which value wins and on which old value is used. The driver task therefore takes every strobe as an argument for a single cycle, so each collision is driven in one call. The expected state is modelled from the values held before the edge. Wrap-around is reached by loading the pointers with FFFFh and 0000h directly before stepping them.

// File: rtl/dptr_pair.sv
module dptr_pair #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic            ld_idx,
  input  logic [BW-1:0]   ld_data,
  input  logic            step_cmd,
  input  logic            auto_step,
  input  logic            ptr_use,
  input  logic            ctl_we,
  input  logic [4:0]      ctl_wdata,
  output logic [2*BW-1:0] addr,
  output logic [2*BW-1:0] ptr0_q,
  output logic [2*BW-1:0] ptr1_q,
  output logic [4:0]      ctl_q
);
  localparam int AW = 2 * BW;

  logic [4:0] ctl;
  wire sel     = ctl[0];
  wire tog_en  = ctl[1];
  wire auto_en = ctl[4];
  wire do_step = step_cmd | (auto_step & auto_en);

  for (genvar i = 0; i < 2; i++) begin : g_ptr
    logic [AW-1:0] q;
    wire hit = (ld_idx == 1'(i));
    wire ld  = hit & (ld_lo | ld_hi);
    wire stp = do_step & (sel == 1'(i)) & ~ld;
    wire dn  = ctl[2+i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld) begin
        if (ld_lo) q[BW-1:0]  <= ld_data;
        if (ld_hi) q[AW-1:BW] <= ld_data;
      end else if (stp) begin
        q <= dn ? q - 1'b1 : q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ctl    <= '0;
    else if (ctl_we)           ctl    <= ctl_wdata;
    else if (tog_en & ptr_use) ctl[0] <= ~ctl[0];
  end

  assign ptr0_q = g_ptr[0].q;
  assign ptr1_q = g_ptr[1].q;
  assign addr   = sel ? g_ptr[1].q : g_ptr[0].q;
  assign ctl_q  = ctl;
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_lo,
  input logic            ld_hi,
  input logic            ld_idx,
  input logic [BW-1:0]   ld_data,
  input logic            step_cmd,
  input logic            auto_step,
  input logic            ptr_use,
  input logic            ctl_we,
  input logic [4:0]      ctl_wdata,
  input logic [2*BW-1:0] addr,
  input logic [2*BW-1:0] ptr0_q,
  input logic [2*BW-1:0] ptr1_q,
  input logic [4:0]      ctl_q
);
  localparam int AW = 2 * BW;

  AST_ADDR_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    addr == (ctl_q[0] ? ptr1_q : ptr0_q)); // R3

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_q == $past(ctl_wdata)); // R2

  AST_STEP_UP0: assert property (@(posedge clk) disable iff (!rst_n)
    step_cmd && !ctl_q[0] && !ctl_q[2] && !((ld_lo || ld_hi) && !ld_idx)
    |=> ptr0_q == AW'($past(ptr0_q) + 1'b1)); // R5

  AST_AUTO_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    auto_step && !step_cmd && !ctl_q[4] && !ld_lo && !ld_hi
    |=> ptr0_q == $past(ptr0_q) && ptr1_q == $past(ptr1_q)); // R7

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && ctl_q[1] && ptr_use |=> ctl_q[0] != $past(ctl_q[0])); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo && !ld_idx |=> ptr0_q[BW-1:0] == $past(ld_data)); // R10
endmodule

bind dptr_pair dptr_pair_chk #(.BW(BW)) u_chk (.*);

// File: tb/sim_dptr_pair.sv
`timescale 1ns/1ps
module sim_dptr_pair;
  logic clk = 0;
  logic rst_n = 0;
  logic ld_lo = 0, ld_hi = 0, ld_idx = 0;
  logic [7:0] ld_data = 0;
  logic step_cmd = 0, auto_step = 0, ptr_use = 0, ctl_we = 0;
  logic [4:0] ctl_wdata = 0;
  logic [15:0] addr, ptr0_q, ptr1_q;
  logic [4:0] ctl_q;

  always #4 clk = ~clk;

  dptr_pair u0 (.*);

  typedef struct packed {
    logic [15:0] p0;
    logic [15:0] p1;
    logic [4:0]  c;
    logic [15:0] a;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  logic [15:0] m_p0 = 0, m_p1 = 0;
  logic [4:0]  m_c = 0;
  bit done = 0;

  task automatic push_exp(input string tag);
    item_t it;
    it.p0 = m_p0; it.p1 = m_p1; it.c = m_c;
    it.a = m_c[0] ? m_p1 : m_p0;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic cyc(input logic lo, input logic hi, input logic idx, input logic [7:0] d,
                     input logic st, input logic au, input logic us,
                     input logic we, input logic [4:0] wd, input string tag);
    logic ds;
    logic [15:0] n0, n1;
    logic [4:0] nc;
    @(negedge clk);
    ld_lo = lo; ld_hi = hi; ld_idx = idx; ld_data = d;
    step_cmd = st; auto_step = au; ptr_use = us; ctl_we = we; ctl_wdata = wd;
    ds = st | (au & m_c[4]);
    n0 = m_p0; n1 = m_p1; nc = m_c;
    if ((lo | hi) && !idx) begin
      if (lo) n0[7:0] = d;
      if (hi) n0[15:8] = d;
    end else if (ds && !m_c[0]) n0 = m_c[2] ? m_p0 - 16'd1 : m_p0 + 16'd1;
    if ((lo | hi) && idx) begin
      if (lo) n1[7:0] = d;
      if (hi) n1[15:8] = d;
    end else if (ds && m_c[0]) n1 = m_c[3] ? m_p1 - 16'd1 : m_p1 + 16'd1;
    if (we) nc = wd;
    else if (m_c[1] && us) nc[0] = ~nc[0];
    @(posedge clk);
    m_p0 = n0; m_p1 = n1; m_c = nc;
    push_exp(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, 5'h00, tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ptr0_q !== e.p0 || ptr1_q !== e.p1 || ctl_q !== e.c || addr !== e.a) begin
        errors++;
        $display("FAIL %s: got p0=%h p1=%h ctl=%h addr=%h exp p0=%h p1=%h ctl=%h addr=%h",
                 t, ptr0_q, ptr1_q, ctl_q, addr, e.p0, e.p1, e.c, e.a);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ptr0_q !== 0 || ptr1_q !== 0 || ctl_q !== 0 || addr !== 0) begin
      errors++;
      $display("FAIL R1 in reset: got p0=%h p1=%h ctl=%h addr=%h exp all 0", ptr0_q, ptr1_q, ctl_q, addr);
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); push_exp("R1 after release");
    cyc(1, 1, 0, 8'h34, 0, 0, 0, 0, 0, "R4 both bytes p0");
    cyc(0, 1, 0, 8'h12, 0, 0, 0, 0, 0, "R4 high byte p0");
    cyc(1, 1, 1, 8'hFF, 0, 0, 0, 0, 0, "R4 load p1");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 step up p0");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'b00100, "R2 dir0 down");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 step down p0");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'b00001, "R3 select p1");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 wrap up p1");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'b01001, "R2 dir1 down");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 wrap down p1");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R7 auto ignored");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'b11001, "R2 auto enable");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R7 auto step");
    cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, "R8 single step");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 use without toggle");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'b11011, "R2 toggle enable");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 toggle flips");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, "R11 step before toggle");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 5'b10011, "R9 write over toggle");
    cyc(1, 0, 1, 8'hAA, 1, 0, 0, 0, 0, "R10 load beats step");
    cyc(0, 0, 0, 0, 1, 0, 0, 1, 5'b01000, "R11 old dir and sel");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 inactive unchanged");
    idle("R3 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule